// File: doc/BRIEF.md
# Asynchronous Serial Port with 32x Oversampled Baud Generator

This block is a full-duplex asynchronous serial port. A transmitter turns a byte written over a small register bus into a serial frame on `txd`. An independent receiver recovers frames from `rxd` and holds the received character until software or a DMA engine reads it. Both sides share one baud generator. The generator raises an oversample tick once every divisor+1 clocks, so the divisor register holds clk/(32 × baud) − 1 and every serial bit lasts 32 ticks.

Each frame has a low start bit, then 7 or 8 data bits sent least significant bit first, then an optional odd or even parity bit, then one or two high stop bits. The line is high when idle. The receiver confirms a start bit at its midpoint and then samples each later bit at its own midpoint. It reports parity errors, framing errors, overruns and line breaks through sticky status flags. These flags drive interrupt lines. The transmit-ready and receive-full conditions drive both interrupt lines and DMA request lines.

Register map. Address 0 is data: a write loads the transmitter, and a read returns the received character and frees the receive buffer. Address 1 is configuration. Address 2 is status: a read returns the flags, and writing 1 to an error bit clears that bit. Address 3 is the baud divisor.

Top module: `uart32_port`

## Requirements
- R1: The baud generator ticks once every div+1 clocks, where div is the 8-bit value at address 3. Every serial bit after the start bit lasts exactly 32·(div+1) clocks. The start bit lasts between 31·(div+1) and 32·(div+1) clocks.
- R2: The idle line is high. Writing address 0 while the transmitter is ready makes `txd` go low on the next cycle to begin the start bit. The data bits follow least significant bit first, then parity if enabled, then the stop bits, which are high.
- R3: Configuration bit 0 selects the character length: 1 gives 8 data bits, 0 gives 7 data bits. In 7-bit mode, bit 7 of a received character reads as 0.
- R4: Configuration bit 1 enables parity and bit 2 selects odd parity (1) or even parity (0). The parity bit makes the count of ones over data plus parity odd or even as selected.
- R5: Configuration bit 3 selects two stop bits (1) or one stop bit (0). Transmit-ready (status bit 0, `irq_tx`) stays low through the last stop bit and rises after it.
- R6: The receiver accepts a start bit only if `rxd` is still low 16 ticks after the falling edge. A shorter low pulse is ignored. A good frame loads the data register and sets receive-full (status bit 1, `irq_rx`). Reading address 0 clears receive-full.
- R7: A parity mismatch sets status bit 4. The character is still delivered.
- R8: A low stop bit after a frame that is not all zeros sets the framing flag (status bit 3). The character is discarded.
- R9: A frame whose data bits, parity bit and stop bit are all low sets the break flag (status bit 2) and `irq_brk`. It does not set the framing flag.
- R10: A good frame that completes while receive-full is set sets the overrun flag (status bit 5). The new character is discarded and the old one is kept.
- R11: A write to address 0 while the transmitter is busy is ignored. The frame in flight is not altered.
- R12: Status bits 2 to 5 are sticky until a status write with a 1 in that bit position clears them. `irq_err` is high while any of the framing, parity or overrun flags is set.
- R13: `dma_tx_req` follows transmit-ready and `dma_rx_req` follows receive-full. Transmit and receive run at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 0 frees the receive buffer) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from addr) |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq_tx | output | 1 | Transmitter ready |
| irq_rx | output | 1 | Received character waiting |
| irq_brk | output | 1 | Break detected |
| irq_err | output | 1 | Framing, parity or overrun flag set |
| dma_tx_req | output | 1 | DMA request: transmitter can take a byte |
| dma_rx_req | output | 1 | DMA request: received byte waiting |

## Verification
Transmit timing is checked relative to the falling edge of `txd` rather than the bus write. Each frame bit is sampled 16·(div+1) clocks after that edge plus 32·(div+1) clocks per bit. This keeps every sample about half a bit away from any edge, whatever the tick phase at load time. `irq_tx` is checked low at the last stop-bit sample and high 16·(div+1)+2 clocks later. Receive results are due at the middle of the stop bit, at most 16·(div+1) clocks plus two synchroniser cycles after the bench starts that stop bit. The bench therefore reads status only after the whole stop period has elapsed, plus a few idle clocks. The divisor check counts clocks between `txd` edges: an exact 32·(div+1) for a data bit, and a window one tick wide for the start bit.

// File: rtl/uart32_pkg.sv
package uart32_pkg;
  typedef struct packed {
    logic two_stop;
    logic odd;
    logic par_en;
    logic char8;
  } cfg_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_BITS, RX_STOP, RX_WAITH
  } rx_st_t;
endpackage

// File: rtl/uart32_baud.sv
module uart32_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_n;

  assign tick = (cnt_q == div);

  always_comb begin
    cnt_n = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/uart32_tx.sv
module uart32_tx
  import uart32_pkg::*;
#(
  parameter int OVS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  cfg_t       cfg,
  input  logic       load,
  input  logic [7:0] din,
  output logic       txd,
  output logic       busy
);
  localparam int OW = $clog2(OVS);
  localparam int FW = 12;

  logic [FW-1:0] sr_q, sr_n, frame;
  logic [3:0]    left_q, left_n, len, nd;
  logic [OW-1:0] tc_q, tc_n;
  logic          busy_q, busy_n;
  logic [7:0]    dm;

  // frame image built from the configuration at load time
  always_comb begin
    nd    = cfg.char8 ? 4'd8 : 4'd7;
    dm    = {cfg.char8 & din[7], din[6:0]};
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 7 || cfg.char8) frame[i+1] = din[i];
    if (cfg.par_en) frame[nd+4'd1] = (^dm) ^ cfg.odd;
    len = nd + {3'b0, cfg.par_en} + 4'd2 + {3'b0, cfg.two_stop};
  end

  always_comb begin
    sr_n = sr_q; left_n = left_q; tc_n = tc_q; busy_n = busy_q;
    if (!busy_q && load) begin
      sr_n = frame; left_n = len; tc_n = '0; busy_n = 1'b1;
    end else if (busy_q && tick) begin
      if (tc_q == OW'(OVS-1)) begin
        tc_n   = '0;
        sr_n   = {1'b1, sr_q[FW-1:1]};
        left_n = left_q - 4'd1;
        if (left_q == 4'd1) busy_n = 1'b0;
      end else begin
        tc_n = tc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '1; left_q <= '0; tc_q <= '0; busy_q <= 1'b0;
    end else begin
      sr_q <= sr_n; left_q <= left_n; tc_q <= tc_n; busy_q <= busy_n;
    end
  end

  assign busy = busy_q;
  assign txd  = busy_q ? sr_q[0] : 1'b1;
endmodule

// File: rtl/uart32_rx.sv
module uart32_rx
  import uart32_pkg::*;
#(
  parameter int OVS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  cfg_t       cfg,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] data,
  output logic       perr,
  output logic       ferr,
  output logic       brk
);
  localparam int OW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  rx_st_t        st_q, st_n;
  logic [OW-1:0] tc_q, tc_n;
  logic [3:0]    bi_q, bi_n, nd, ntot;
  logic [8:0]    sr_q, sr_n;
  logic          s1_q, s2_q, allz;

  always_comb begin
    nd   = cfg.char8 ? 4'd8 : 4'd7;
    ntot = nd + {3'b0, cfg.par_en};
    data = {cfg.char8 & sr_q[7], sr_q[6:0]};
    perr = cfg.par_en & (sr_q[nd] ^ (^data) ^ cfg.odd);
    allz = 1'b1;
    for (int i = 0; i < 9; i++)
      if (4'(i) < ntot && sr_q[i]) allz = 1'b0;
  end

  always_comb begin
    st_n = st_q; tc_n = tc_q; bi_n = bi_q; sr_n = sr_q;
    done = 1'b0; ferr = 1'b0; brk = 1'b0;
    case (st_q)
      RX_IDLE:
        if (!s2_q) begin st_n = RX_START; tc_n = '0; end
      RX_START:
        if (tick) begin
          if (tc_q == OW'(HALF-1)) begin
            if (!s2_q) begin st_n = RX_BITS; tc_n = '0; bi_n = '0; end
            else st_n = RX_IDLE;
          end else tc_n = tc_q + 1'b1;
        end
      RX_BITS:
        if (tick) begin
          if (tc_q == OW'(OVS-1)) begin
            sr_n[bi_q] = s2_q;
            tc_n = '0;
            if (bi_q == ntot - 4'd1) st_n = RX_STOP;
            else bi_n = bi_q + 4'd1;
          end else tc_n = tc_q + 1'b1;
        end
      RX_STOP:
        if (tick) begin
          if (tc_q == OW'(OVS-1)) begin
            tc_n = '0;
            if (s2_q) begin done = 1'b1; st_n = RX_IDLE; end
            else begin
              if (allz) brk = 1'b1; else ferr = 1'b1;
              st_n = RX_WAITH;
            end
          end else tc_n = tc_q + 1'b1;
        end
      default:
        if (s2_q) st_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1; s2_q <= 1'b1; st_q <= RX_IDLE;
      tc_q <= '0; bi_q <= '0; sr_q <= '0;
    end else begin
      s1_q <= rxd; s2_q <= s1_q; st_q <= st_n;
      tc_q <= tc_n; bi_q <= bi_n; sr_q <= sr_n;
    end
  end
endmodule

// File: rtl/uart32_port.sv
module uart32_port
  import uart32_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS   = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq_tx,
  output logic       irq_rx,
  output logic       irq_brk,
  output logic       irq_err,
  output logic       dma_tx_req,
  output logic       dma_rx_req
);
  logic [3:0]       ctrl_q, ctrl_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [7:0]       rbuf_q, rbuf_n, rx_data;
  logic             full_q, full_n;
  logic [3:0]       flg_q, flg_n;   // {overrun, parity, framing, break}
  logic             tick, tx_busy, rx_done, rx_perr, rx_ferr, rx_brk;
  logic             wr_dat, rd_dat;
  cfg_t             cfg;

  assign cfg    = cfg_t'(ctrl_q);
  assign wr_dat = wr_en && addr == 2'd0;
  assign rd_dat = rd_en && addr == 2'd0;

  uart32_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick));

  uart32_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .load(wr_dat),
    .din(wdata), .txd(txd), .busy(tx_busy));

  uart32_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .rxd(rxd),
    .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr),
    .brk(rx_brk));

  always_comb begin
    ctrl_n = ctrl_q; div_n = div_q; rbuf_n = rbuf_q;
    full_n = full_q && !rd_dat;
    flg_n  = flg_q;
    if (wr_en && addr == 2'd1) ctrl_n = wdata[3:0];
    if (wr_en && addr == 2'd3) div_n  = DIV_W'(wdata);
    if (wr_en && addr == 2'd2) flg_n  = flg_q & ~wdata[5:2];
    if (rx_brk)  flg_n[0] = 1'b1;
    if (rx_ferr) flg_n[1] = 1'b1;
    if (rx_done) begin
      if (full_q) flg_n[3] = 1'b1;
      else begin
        rbuf_n   = rx_data;
        full_n   = 1'b1;
        flg_n[2] = flg_n[2] | rx_perr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 4'h1; div_q <= '0; rbuf_q <= '0; full_q <= 1'b0; flg_q <= '0;
    end else begin
      ctrl_q <= ctrl_n; div_q <= div_n; rbuf_q <= rbuf_n;
      full_q <= full_n; flg_q <= flg_n;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = rbuf_q;
      2'd1:    rdata = {4'b0, ctrl_q};
      2'd2:    rdata = {2'b0, flg_q, full_q, !tx_busy};
      default: rdata = 8'(div_q);
    endcase
  end

  assign irq_tx     = !tx_busy;
  assign irq_rx     = full_q;
  assign irq_brk    = flg_q[0];
  assign irq_err    = |flg_q[3:1];
  assign dma_tx_req = !tx_busy;
  assign dma_rx_req = full_q;
endmodule

// File: rtl/uart32_port_chk.sv
module uart32_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic       txd,
  input logic       irq_tx,
  input logic       irq_rx,
  input logic       irq_brk,
  input logic       irq_err
);
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> txd);

  p_load_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && irq_tx) |=> (!irq_tx && !txd));

  p_busy_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && !irq_tx) |=> !irq_tx);

  p_read_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0) |=> !irq_rx);

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_err && !(wr_en && addr == 2'd2)) |=> irq_err);

  p_brk_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_brk && !(wr_en && addr == 2'd2)) |=> irq_brk);
endmodule

bind uart32_port uart32_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_brk(irq_brk),
  .irq_err(irq_err));

// File: tb/uart32_port_tb.sv
module uart32_port_tb;
  logic       clk, rst_n, wr_en, rd_en, rxd;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       txd, irq_tx, irq_rx, irq_brk, irq_err, dma_tx_req, dma_rx_req;
  int         n_chk, n_err, p;
  logic [7:0] rv;

  uart32_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq_tx(irq_tx),
    .irq_rx(irq_rx), .irq_brk(irq_brk), .irq_err(irq_err),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_bits(input int nb);
    repeat (nb * 32 * p) @(negedge clk);
  endtask

  // drive one frame on rxd; stop_val 0 forces a bad stop bit
  task automatic send_rx(input logic [7:0] d, input logic [3:0] c,
                         input logic bad_par, input logic stop_val);
    int nd;
    logic [7:0] dm;
    nd = c[0] ? 8 : 7;
    dm = c[0] ? d : {1'b0, d[6:0]};
    @(negedge clk); rxd = 1'b0; wait_bits(1);
    for (int i = 0; i < nd; i++) begin rxd = dm[i]; wait_bits(1); end
    if (c[1]) begin rxd = (^dm) ^ c[2] ^ bad_par; wait_bits(1); end
    rxd = stop_val; wait_bits(1);
    if (c[3]) begin rxd = 1'b1; wait_bits(1); end
    rxd = 1'b1;
  endtask

  // capture one transmitted frame and compare with the computed image
  task automatic cap_tx(input logic [7:0] d, input logic [3:0] c, input string tag);
    int nd, nb;
    logic [7:0]  dm;
    logic [11:0] exp_f, got;
    nd = c[0] ? 8 : 7;
    dm = c[0] ? d : {1'b0, d[6:0]};
    nb = 1 + nd + int'(c[1]) + 1 + int'(c[3]);
    exp_f = '0; got = '0;
    for (int i = 0; i < nd; i++) exp_f[i+1] = dm[i];
    if (c[1]) exp_f[nd+1] = (^dm) ^ c[2];
    for (int i = nd + 1 + int'(c[1]); i < nb; i++) exp_f[i] = 1'b1;
    while (txd) @(negedge clk);
    repeat (16 * p) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      if (i > 0) wait_bits(1);
      got[i] = txd;
      if (i == nb - 1) chk({"R5 ready low in last stop ", tag}, int'(irq_tx), 0);
    end
    chk({"R2 R3 R4 tx frame ", tag}, int'(got), int'(exp_f));
    repeat (16 * p + 2) @(negedge clk);
    chk({"R5 R13 ready after stop ", tag}, int'({irq_tx, dma_tx_req}), 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0; p = 1;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; rxd = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset txd idle", int'(txd), 1);
    chk("R13 reset requests", int'({dma_tx_req, dma_rx_req, irq_rx, irq_err, irq_brk}), 5'b10000);
    bus_rd(2'd2, rv); chk("R12 reset status", int'(rv), 8'h01);

    // R1: bit timing with divisor 3
    bus_wr(2'd3, 8'd3); p = 4;
    bus_wr(2'd1, 8'h01);
    bus_wr(2'd0, 8'h55);
    begin
      int l0, l1;
      l0 = 0; l1 = 0;
      while (txd) @(negedge clk);
      while (!txd) begin l0++; @(negedge clk); end
      while (txd) begin l1++; @(negedge clk); end
      chk("R1 start bit length in window", int'(l0 >= 31 * p && l0 <= 32 * p + 1), 1);
      chk("R1 data bit length", l1, 32 * p);
    end
    while (!irq_tx) @(negedge clk);

    // full-duplex sweep over all configurations, divisor 1
    bus_wr(2'd3, 8'd1); p = 2;
    repeat (600) @(negedge clk);
    for (int ci = 0; ci < 16; ci++) begin
      if (ci[1] == 1'b0 && ci[2] == 1'b1) continue;
      bus_wr(2'd1, 8'(ci));
      for (int k = 0; k < 3; k++) begin
        logic [7:0] tch, rch;
        string tag;
        tch = 8'((ci * 53 + k * 97 + 5));
        rch = tch ^ 8'hA6 ^ 8'(k);
        tag = $sformatf("cfg=%0h k=%0d", ci, k);
        fork
          begin bus_wr(2'd0, tch); cap_tx(tch, 4'(ci), tag); end
          send_rx(rch, 4'(ci), 1'b0, 1'b1);
        join
        repeat (4) @(negedge clk);
        chk({"R6 R13 rx request ", tag}, int'(dma_rx_req), 1);
        bus_rd(2'd2, rv); chk({"R6 R4 status full ", tag}, int'(rv), 8'h03);
        bus_rd(2'd0, rv);
        chk({"R3 R6 rx data ", tag}, int'(rv), int'(ci[0] ? rch : {1'b0, rch[6:0]}));
        bus_rd(2'd2, rv); chk({"R6 read frees ", tag}, int'(rv), 8'h01);
      end
    end

    // R6: short low pulse rejected
    bus_wr(2'd1, 8'h01);
    @(negedge clk); rxd = 1'b0; repeat (8 * p) @(negedge clk); rxd = 1'b1;
    wait_bits(12);
    bus_rd(2'd2, rv); chk("R6 glitch ignored", int'(rv), 8'h01);

    // R7: parity error, character kept
    bus_wr(2'd1, 8'h03);
    send_rx(8'h5B, 4'h3, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R7 R12 irq_err on parity", int'(irq_err), 1);
    bus_rd(2'd2, rv); chk("R7 status parity", int'(rv), 8'h13);
    bus_rd(2'd0, rv); chk("R7 data delivered", int'(rv), 8'h5B);
    bus_wr(2'd2, 8'h10);
    bus_rd(2'd2, rv); chk("R12 parity cleared", int'({irq_err, rv}), 9'h001);

    // R8: framing error, character discarded
    bus_wr(2'd1, 8'h01);
    send_rx(8'h81, 4'h1, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    bus_rd(2'd2, rv); chk("R8 status framing", int'(rv), 8'h09);
    chk("R8 R12 irq_err on framing", int'({irq_err, irq_rx}), 2'b10);
    bus_wr(2'd2, 8'h08);
    bus_rd(2'd2, rv); chk("R12 framing cleared", int'(rv), 8'h01);

    // R9: break
    @(negedge clk); rxd = 1'b0; wait_bits(11); rxd = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(2'd2, rv); chk("R9 status break", int'(rv), 8'h05);
    chk("R9 irq_brk without irq_err", int'({irq_brk, irq_err}), 2'b10);
    bus_wr(2'd2, 8'h04);
    chk("R9 R12 break cleared", int'(irq_brk), 0);

    // R10: overrun keeps the first character
    send_rx(8'h11, 4'h1, 1'b0, 1'b1);
    send_rx(8'h22, 4'h1, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    bus_rd(2'd2, rv); chk("R10 status overrun", int'(rv), 8'h23);
    bus_rd(2'd0, rv); chk("R10 first char kept", int'(rv), 8'h11);
    bus_rd(2'd2, rv); chk("R10 overrun sticky after read", int'(rv), 8'h21);
    bus_wr(2'd2, 8'h20);
    bus_rd(2'd2, rv); chk("R12 overrun cleared", int'({irq_err, rv}), 9'h001);

    // R11: write during transmission ignored
    fork
      cap_tx(8'h0F, 4'h1, "R11 busy write");
      begin bus_wr(2'd0, 8'h0F); repeat (100) @(negedge clk); bus_wr(2'd0, 8'hF0); end
    join
    wait_bits(12);
    chk("R11 no second frame", int'({txd, irq_tx}), 2'b11);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule